// File: doc/BRIEF.md
# SPI Command Engine with Shared Byte Buffer

This block is a single-lane SPI master for short flash commands such as status reads, identification reads and register writes. Software first loads a small byte buffer through 32-bit word accesses. The buffer holds the complete outgoing stream: the opcode, then the address bytes with the most significant byte first, then the dummy bytes, then any write data. Software then programs an outgoing byte count, an incoming byte count and an SCK divider. Setting the enable and trigger bits starts the transfer.

The engine holds chip select low for the whole frame. It shifts the outgoing bytes out on MOSI in SPI mode 0, most significant bit first. It then clocks in the requested number of incoming bytes and writes each one back into the same buffer. Received byte i lands at byte position txlen + i, so a response can start in the middle of a 32-bit word.

Completion uses a two-step handshake. The ready flag rises when the command is accepted. The busy flag then falls when the frame has ended. Clearing enable and trigger brings the engine back to idle.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the control word reads 0, spi_cs_n is 1, spi_sck is 0, spi_mosi is 1 and the divider register reads 4.
- R2: Buffer word w sits at byte address 0x100 + 4*w. Bits [7:0] hold buffer byte 4*w and bits [31:24] hold byte 4*w+3. Outgoing byte 0 is the first byte on the wire.
- R3: The control word at address 0x000 has these bits: 0 busy (read only), 1 ready (read only), 2 trigger, 3 enable, 4 lane select. A transfer starts from idle only when trigger=1, enable=1 and lane select=0. While busy is 1, ready is also 1. Ready is still 1 in the cycle in which busy falls.
- R4: The outgoing bytes 0..txlen-1 are sent in buffer order, most significant bit first. MOSI changes only while SCK is low, which is SPI mode 0. MOSI is held at 1 while incoming bytes are clocked and while chip select is high.
- R5: MISO is sampled on each rising SCK edge. Incoming byte i is stored at buffer byte txlen + i.
- R6: spi_cs_n goes low exactly once per transfer. It stays low for 8 * div * (txlen + rxlen) clock cycles and is low only while busy is 1.
- R7: The divider register at 0x00C clamps written values below 2 up to 2. Each SCK period lasts div clock cycles, and the high phase lasts floor(div/2) cycles.
- R8: While trigger and enable stay set after a transfer completes, no new transfer starts and the control word reads 0x0E. Clearing trigger drops ready to 0.
- R9: The length registers (outgoing at 0x004, incoming at 0x008) clamp written values to BUF_BYTES. Incoming bytes whose position lies at or beyond BUF_BYTES are discarded, with no wrap to the start of the buffer.
- R10: While busy is 1, writes to the buffer, the length registers and the divider are ignored.
- R11: Clearing enable during a transfer aborts it. Within two cycles spi_cs_n is 1 and both busy and ready are 0.
- R12: A trigger with both lengths set to 0 completes with ready=1 and busy=0. Chip select is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for the register or buffer access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with BUF_BYTES set to 16 and keeps the defaults for DIV_W and ADDR_W. With a 16-byte buffer, a frame that runs past the end of the buffer is only 18 bytes long, so the discard-without-wrap rule and the length clamp can be reached in a few hundred cycles. A 16-byte buffer still spans four words, which is enough to show a response starting mid-word and a word that must stay untouched. An even and an odd divider are both used, and the 2-cycle minimum is exercised, so the uneven low/high split of SCK and the clamp are covered.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } eng_state_e;

  localparam int CTL_BUSY  = 0;
  localparam int CTL_READY = 1;
  localparam int CTL_TRIG  = 2;
  localparam int CTL_EN    = 3;
  localparam int CTL_LANE  = 4;

  localparam int OFS_CTRL  = 'h000;
  localparam int OFS_TXLEN = 'h004;
  localparam int OFS_RXLEN = 'h008;
  localparam int OFS_DIV   = 'h00C;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 160,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4,
  parameter int ADDR_W    = 9,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              xfer_done,
  output logic [31:0]       rd_data,
  output logic              start,
  output logic              abort,
  output logic              busy,
  output logic [LEN_W-1:0]  tx_len,
  output logic [LEN_W-1:0]  rx_len,
  output logic [DIV_W-1:0]  div
);
  localparam logic [31:0] DIV_MAX = 32'((1 << DIV_W) - 1);

  function automatic logic [LEN_W-1:0] clamp_len(logic [31:0] v);
    if (v > 32'(BUF_BYTES)) return LEN_W'(BUF_BYTES);
    return v[LEN_W-1:0];
  endfunction

  function automatic logic [DIV_W-1:0] clamp_div(logic [31:0] v);
    if (v < 32'd2) return DIV_W'(2);
    if (v > DIV_MAX) return DIV_MAX[DIV_W-1:0];
    return v[DIV_W-1:0];
  endfunction

  eng_state_e st_q, st_d;
  logic en_q, trig_q, lane_q;
  logic ready;
  logic hit_ctrl, hit_tx, hit_rx, hit_div;

  assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign hit_tx   = wr_en && (addr == ADDR_W'(OFS_TXLEN)) && !busy;
  assign hit_rx   = wr_en && (addr == ADDR_W'(OFS_RXLEN)) && !busy;
  assign hit_div  = wr_en && (addr == ADDR_W'(OFS_DIV))   && !busy;

  assign busy  = (st_q == ST_RUN);
  assign ready = (st_q != ST_IDLE);
  assign start = (st_q == ST_IDLE) && en_q && trig_q && !lane_q;
  assign abort = (st_q == ST_RUN) && !en_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_RUN;
      ST_RUN:  if (!en_q) st_d = ST_IDLE;
               else if (xfer_done) st_d = ST_DONE;
      ST_DONE: if (!en_q || !trig_q) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      trig_q <= 1'b0;
      lane_q <= 1'b0;
      tx_len <= '0;
      rx_len <= '0;
      div    <= DIV_W'(DIV_RESET);
    end else begin
      st_q <= st_d;
      if (hit_ctrl) begin
        trig_q <= wdata[CTL_TRIG];
        en_q   <= wdata[CTL_EN];
        lane_q <= wdata[CTL_LANE];
      end
      if (hit_tx)  tx_len <= clamp_len(wdata);
      if (hit_rx)  rx_len <= clamp_len(wdata);
      if (hit_div) div    <= clamp_div(wdata);
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      ADDR_W'(OFS_CTRL): begin
        rd_data[CTL_BUSY]  = busy;
        rd_data[CTL_READY] = ready;
        rd_data[CTL_TRIG]  = trig_q;
        rd_data[CTL_EN]    = en_q;
        rd_data[CTL_LANE]  = lane_q;
      end
      ADDR_W'(OFS_TXLEN): rd_data = 32'(tx_len);
      ADDR_W'(OFS_RXLEN): rd_data = 32'(rx_len);
      ADDR_W'(OFS_DIV):   rd_data = 32'(div);
      default:            rd_data = '0;
    endcase
  end

  p_ready_at_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_q) |-> ready);
  p_div_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div >= DIV_W'(2));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_q && trig_q) |=> !busy);
  p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int BUF_BYTES = 160,
  parameter int WIDX_W    = 6,
  parameter int IDX_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [WIDX_W-1:0] sw_word,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic [IDX_W-1:0]  eng_addr,
  output logic [7:0]        eng_rdata,
  input  logic              rx_we,
  input  logic [IDX_W-1:0]  rx_addr,
  input  logic [7:0]        rx_data
);
  logic [8*BUF_BYTES-1:0] flat;

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
    localparam int WORD = i / 4;
    localparam int LANE = i % 4;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (rx_we && (rx_addr == IDX_W'(i))) q <= rx_data;
      else if (sw_we && (sw_word == WIDX_W'(WORD))) q <= sw_wdata[8*LANE +: 8];
    end
    assign flat[8*i +: 8] = q;
  end

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      logic [WIDX_W+1:0] idx;
      idx = {sw_word, 2'(l)};
      sw_rdata[8*l +: 8] = (int'(idx) < BUF_BYTES) ? flat[8*int'(idx) +: 8] : 8'h00;
    end
  end

  assign eng_rdata = (int'(eng_addr) < BUF_BYTES) ? flat[8*int'(eng_addr) +: 8] : 8'hFF;

  p_rx_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (int'(rx_addr) < BUF_BYTES));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int BUF_BYTES = 160,
  parameter int DIV_W     = 8,
  parameter int LEN_W     = 8,
  parameter int IDX_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [DIV_W-1:0] div,
  output logic [IDX_W-1:0] fetch_addr,
  input  logic [7:0]       fetch_data,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_addr,
  output logic [7:0]       rx_data,
  output logic             done
);
  function automatic logic [DIV_W-1:0] high_len(logic [DIV_W-1:0] d);
    return d >> 1;
  endfunction

  function automatic logic [DIV_W-1:0] low_len(logic [DIV_W-1:0] d);
    return d - high_len(d);
  endfunction

  logic             active;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [IDX_W-1:0] tx_q, tot_q, byte_q;
  logic [2:0]       bit_q;
  logic [7:0]       shreg, rxsh;
  logic [DIV_W-1:0] lo_m1, hi_m1;
  logic [IDX_W-1:0] total;

  logic bit_rise, bit_fall, byte_end, frame_end, in_rx;

  assign total     = IDX_W'(tx_len) + IDX_W'(rx_len);
  assign lo_m1     = low_len(div_q) - 1'b1;
  assign hi_m1     = high_len(div_q) - 1'b1;
  assign bit_rise  = active && !sck && (cnt_q == lo_m1);
  assign bit_fall  = active && sck && (cnt_q == hi_m1);
  assign byte_end  = bit_fall && (bit_q == 3'd7);
  assign frame_end = byte_end && (byte_q == tot_q - 1'b1);
  assign in_rx     = byte_q >= tx_q;
  assign fetch_addr = active ? byte_q + 1'b1 : '0;
  assign mosi      = (cs_n || in_rx) ? 1'b1 : shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sck <= 1'b0; cs_n <= 1'b1; done <= 1'b0;
      div_q <= DIV_W'(2); cnt_q <= '0; tx_q <= '0; tot_q <= '0;
      byte_q <= '0; bit_q <= '0; shreg <= '0; rxsh <= '0;
      rx_we <= 1'b0; rx_addr <= '0; rx_data <= '0;
    end else begin
      done  <= 1'b0;
      rx_we <= 1'b0;
      if (abort) begin
        active <= 1'b0; sck <= 1'b0; cs_n <= 1'b1;
      end else if (start && !active) begin
        if (total == '0) begin
          done <= 1'b1;
        end else begin
          active <= 1'b1; cs_n <= 1'b0; sck <= 1'b0;
          cnt_q <= '0; bit_q <= '0; byte_q <= '0;
          div_q <= div; tx_q <= IDX_W'(tx_len); tot_q <= total;
          shreg <= fetch_data;
        end
      end else if (active) begin
        if (bit_rise) begin
          sck   <= 1'b1;
          cnt_q <= '0;
          rxsh  <= {rxsh[6:0], miso};
        end else if (bit_fall) begin
          sck   <= 1'b0;
          cnt_q <= '0;
          if (byte_end) begin
            bit_q <= '0;
            if (in_rx && (int'(byte_q) < BUF_BYTES)) begin
              rx_we   <= 1'b1;
              rx_addr <= byte_q;
              rx_data <= rxsh;
            end
            if (frame_end) begin
              active <= 1'b0; cs_n <= 1'b1; done <= 1'b1;
            end else begin
              byte_q <= byte_q + 1'b1;
              shreg  <= fetch_data;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
            shreg <= {shreg[6:0], 1'b0};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_sck_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  p_cs_holds_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !frame_end && !abort) |=> !cs_n);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int BUF_BYTES = 160,
  parameter int DIV_W     = 8,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int LEN_W  = $clog2(BUF_BYTES + 1);
  localparam int IDX_W  = $clog2(2 * BUF_BYTES + 1);
  localparam int WIDX_W = ADDR_W - 3;

  logic             buf_hit, busy, start, abort, xfer_done;
  logic [31:0]      regs_rd, buf_rd;
  logic [LEN_W-1:0] tx_len, rx_len;
  logic [DIV_W-1:0] div;
  logic [IDX_W-1:0] fetch_addr, rx_addr;
  logic [7:0]       fetch_data, rx_data;
  logic             rx_we;

  assign buf_hit   = reg_addr[ADDR_W-1];
  assign reg_rdata = buf_hit ? buf_rd : regs_rd;

  spi_cmd_regs #(
    .BUF_BYTES(BUF_BYTES), .DIV_W(DIV_W), .DIV_RESET(4), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && !buf_hit), .addr(reg_addr),
    .wdata(reg_wdata), .xfer_done(xfer_done), .rd_data(regs_rd),
    .start(start), .abort(abort), .busy(busy),
    .tx_len(tx_len), .rx_len(rx_len), .div(div)
  );

  spi_cmd_buffer #(
    .BUF_BYTES(BUF_BYTES), .WIDX_W(WIDX_W), .IDX_W(IDX_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .sw_we(reg_wr && buf_hit && !busy),
    .sw_word(reg_addr[ADDR_W-2:2]), .sw_wdata(reg_wdata), .sw_rdata(buf_rd),
    .eng_addr(fetch_addr), .eng_rdata(fetch_data),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data)
  );

  spi_cmd_shifter #(
    .BUF_BYTES(BUF_BYTES), .DIV_W(DIV_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .tx_len(tx_len), .rx_len(rx_len), .div(div),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data), .done(xfer_done)
  );

  p_cs_within_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  p_rx_write_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> busy);
endmodule

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  localparam int BUF = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0, fails = 0;
  int bitn = 0, cs_falls = 0, cs_low = 0;
  logic [7:0] resp [0:63];
  logic [7:0] cap  [0:63];
  longint last_rise = 0, per_min, per_max, hi_min, hi_max;
  bit have_rise = 0;

  always #10 clk = ~clk;

  spi_cmd_engine #(.BUF_BYTES(BUF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  assign spi_miso = (bitn < 512) ? resp[bitn/8][7 - (bitn%8)] : 1'b0;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) bitn <= 0;
    else begin
      cap[bitn/8] <= {cap[bitn/8][6:0], spi_mosi};
      bitn <= bitn + 1;
    end
  end
  always @(negedge spi_cs_n) cs_falls++;
  always @(posedge clk) if (spi_cs_n === 1'b0) cs_low++;
  always @(posedge spi_sck) begin
    if (have_rise) begin
      if ($time - last_rise < per_min) per_min = $time - last_rise;
      if ($time - last_rise > per_max) per_max = $time - last_rise;
    end
    last_rise = $time; have_rise = 1;
  end
  always @(negedge spi_sck) begin
    if ($time - last_rise < hi_min) hi_min = $time - last_rise;
    if ($time - last_rise > hi_max) hi_max = $time - last_rise;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  function automatic logic [31:0] rword(int b);
    return {resp[b+3], resp[b+2], resp[b+1], resp[b]};
  endfunction

  task automatic begin_xfer(input int tx, input int rx, input int dv);
    wr(9'h004, tx); wr(9'h008, rx); wr(9'h00C, dv);
    cs_falls = 0; cs_low = 0; have_rise = 0;
    per_min = 1e9; per_max = 0; hi_min = 1e9; hi_max = 0;
    wr(9'h000, 32'h0C);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int bad = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(9'h000, v);
      if (v[0] && !v[1]) bad++;
      if (!v[0]) break;
    end
    chk(req, bad, 0);
    chk(req, v[1:0], 2'b10);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(9'h000, v); chk("R1 ctrl", v, 0);
    chk("R1 cs_n", spi_cs_n, 1); chk("R1 sck", spi_sck, 0);
    chk("R1 mosi", spi_mosi, 1);
    rd(9'h00C, v); chk("R1 div", v, 4);
  endtask

  task automatic t_div_clamp;
    logic [31:0] v;
    wr(9'h00C, 1); rd(9'h00C, v); chk("R7 clamp 1", v, 2);
    wr(9'h00C, 0); rd(9'h00C, v); chk("R7 clamp 0", v, 2);
  endtask

  task automatic t_read_cmd;
    logic [31:0] v;
    logic [7:0] txb [0:4];
    txb = '{8'h0B, 8'h12, 8'h34, 8'h56, 8'hA5};
    wr(9'h100, 32'h5634120B); wr(9'h104, 32'h777777A5);
    rd(9'h100, v); chk("R2 word readback", v, 32'h5634120B);
    begin_xfer(5, 3, 4);
    wait_idle("R3 handshake");
    for (int k = 0; k < 5; k++) chk("R4 tx byte order", cap[k], txb[k]);
    for (int k = 5; k < 8; k++) chk("R4 mosi high in rx", cap[k], 8'hFF);
    rd(9'h104, v); chk("R5 rx mid-word", v, {resp[7], resp[6], resp[5], 8'hA5});
    rd(9'h100, v); chk("R5 tx word kept", v, 32'h5634120B);
    chk("R6 cs low cycles", cs_low, 8*4*8);
    chk("R6 one frame", cs_falls, 1);
    chk("R7 period div4", 32'(per_max), 80); chk("R7 period min", 32'(per_min), 80);
    chk("R7 high div4", 32'(hi_max), 40);
    repeat (40) @(negedge clk);
    rd(9'h000, v); chk("R8 hold trigger", v, 32'h0E);
    chk("R8 no restart", cs_falls, 1);
    wr(9'h000, 32'h08); rd(9'h000, v); chk("R8 ready clears", v, 32'h08);
  endtask

  task automatic t_odd_div;
    logic [31:0] v;
    wr(9'h100, 32'h0000009F);
    begin_xfer(1, 1, 5);
    wait_idle("R3 odd div");
    chk("R4 opcode", cap[0], 8'h9F);
    chk("R7 period div5", 32'(per_max), 100);
    chk("R7 high div5", 32'(hi_min), 40);
    chk("R6 cs low div5", cs_low, 8*5*2);
    rd(9'h100, v); chk("R5 rx at 1", v[15:8], resp[1]);
    wr(9'h000, 0);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    cs_falls = 0;
    wr(9'h000, 32'h1C); repeat (20) @(negedge clk);
    rd(9'h000, v); chk("R3 lane blocks", v, 32'h1C);
    wr(9'h000, 32'h04); repeat (20) @(negedge clk);
    rd(9'h000, v); chk("R3 enable needed", v, 32'h04);
    chk("R3 no frame", cs_falls, 0);
    wr(9'h000, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(9'h004, 200); rd(9'h004, v); chk("R9 txlen clamp", v, BUF);
    wr(9'h100, 32'h03020100); wr(9'h104, 32'h07060504);
    wr(9'h108, 32'h0B0A0908); wr(9'h10C, 32'h0F0E0D0C);
    begin_xfer(14, 4, 2);
    wait_idle("R9 handshake");
    rd(9'h100, v); chk("R9 no wrap", v, 32'h03020100);
    rd(9'h10C, v); chk("R9 tail bytes", v, {resp[15], resp[14], 8'h0D, 8'h0C});
    chk("R6 cs low div2", cs_low, 8*2*18);
    for (int k = 0; k < 14; k++) chk("R4 long tx", cap[k], 8'(k));
    wr(9'h000, 0);
  endtask

  task automatic t_busy_writes;
    logic [31:0] v;
    wr(9'h100, 32'h0000C3A1); wr(9'h10C, 32'h13572468);
    begin_xfer(2, 2, 8);
    repeat (10) @(negedge clk);
    wr(9'h10C, 32'hDEADBEEF); wr(9'h004, 9); wr(9'h00C, 3);
    wait_idle("R10 handshake");
    rd(9'h10C, v); chk("R10 buffer write ignored", v, 32'h13572468);
    rd(9'h004, v); chk("R10 txlen write ignored", v, 2);
    rd(9'h00C, v); chk("R10 div write ignored", v, 8);
    rd(9'h100, v); chk("R5 rx after 2", v, {resp[3], resp[2], 8'hC3, 8'hA1});
    wr(9'h000, 0);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    begin_xfer(4, 4, 8);
    repeat (20) @(negedge clk);
    chk("R11 running", spi_cs_n, 0);
    wr(9'h000, 32'h04);
    @(negedge clk);
    chk("R11 cs released", spi_cs_n, 1);
    rd(9'h000, v); chk("R11 idle", v, 32'h04);
    wr(9'h000, 0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    begin_xfer(0, 0, 2);
    repeat (5) @(negedge clk);
    rd(9'h000, v); chk("R12 zero done", v, 32'h0E);
    chk("R12 no cs", cs_falls, 0);
    wr(9'h000, 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      resp[k] = 8'(8'h5A + 37*k);
      cap[k] = 8'h00;
    end
    per_min = 1e9; per_max = 0; hi_min = 1e9; hi_max = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset; t_div_clamp; t_read_cmd; t_odd_div; t_gating;
        t_overflow; t_busy_writes; t_abort; t_zero;
      end
      begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule